// File: doc/BRIEF.md
# CAN Frame-Complete Timestamp Link

This block turns the "frame accepted" event of a CAN receiver into a hardware timestamp. When the receiver reports a frame that reached the end of its end-of-frame field with no error, the block raises a pulse that lasts a set number of CAN bit times. The receiver also sees the frames this node sends, so frames the node transmitted and read back produce the pulse too. The pulse length is counted from a bit-time tick input.

A link-enable input picks the source of the capture channel. When the link is on, the channel takes its input from the internal pulse. When the link is off, it takes its input from an external capture input. The channel captures on a rising edge. It compares its source with a copy delayed by one register, so each pulse gives exactly one capture. On a capture the channel stores the value of a free-running 16-bit timer and sets a sticky flag. If a capture arrives while the flag is still set, the stored value is overwritten and an overrun bit is set. Software reads the stored value and keeps it with the received message.

The route only switches while the pulse is low. At the switch, the delay register is loaded with the level of the new source, so changing the link bit never creates a false edge.

Top module: `can_rx_tstamp_link`

## Requirements
- R1: `link_pulse_o` goes high in the cycle after a cycle in which `frame_ok_i` is sampled high while the pulse is low. It never goes high without such a strobe.
- R2: The pulse stays high until `PULSE_BITS` cycles with `bit_tick_i` high have been sampled while it is high (default 1). It goes low in the cycle after the last of those ticks.
- R3: A `frame_ok_i` strobe sampled while the pulse is high is ignored. It neither stretches the pulse nor restarts it.
- R4: While the route selects the link, each rising edge of the pulse causes exactly one capture, one cycle after the pulse rises. While the route selects the external input, each rising edge of `ext_cap_i` causes one capture, in the cycle `ext_cap_i` is first sampled high.
- R5: `timer_o` is 0 after reset. It increases by one on each cycle with `tmr_tick_i` high, holds its value otherwise, and wraps from 0xFFFF to 0x0000.
- R6: On a capture, `tstamp_o` takes the value `timer_o` had just before that clock edge. `tstamp_o` changes at no other time.
- R7: A capture sets `cap_flag_o`. Pulsing `flag_clr_i` clears both `cap_flag_o` and `overrun_o`. If a capture and a clear happen in the same cycle, the capture wins: the flag ends up at 1 and overrun at 0.
- R8: A capture while `cap_flag_o` is 1 and no clear is present sets `overrun_o`. The overrun bit stays set until it is cleared.
- R9: The route follows `link_en_i` only in cycles where the pulse is low. A change of route never produces a capture by itself.
- R10: Reset is synchronous and active high. It leaves the pulse, flag, overrun, timestamp and timer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_ok_i | input | 1 | One-cycle strobe: a frame finished its end-of-frame field with no error |
| bit_tick_i | input | 1 | One-cycle tick, once per CAN bit time |
| link_en_i | input | 1 | 1 routes the pulse into the capture channel |
| ext_cap_i | input | 1 | External capture input, used while the link is off (synchronous) |
| tmr_tick_i | input | 1 | Prescale tick that advances the timer |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag and overrun bits |
| link_pulse_o | output | 1 | Frame-complete pulse, one or more bit times wide |
| timer_o | output | 16 | Free-running timer value |
| tstamp_o | output | 16 | Captured timestamp |
| cap_flag_o | output | 1 | Sticky capture flag |
| overrun_o | output | 1 | A capture overwrote an unread timestamp |

## Verification
The block is driven with random strobes, ticks, route changes and clears. This mix tells apart several cases:
- strobes that start a pulse and strobes that arrive during one and must be ignored;
- captures that come from the pulse and captures that come from the external input;
- a capture and a clear landing in the same cycle;
- first captures and overrun captures.

Directed cases cover the following:
- a long run of timer ticks across the 0xFFFF wrap;
- dropping the link bit while the pulse is high with the external input held high, where any false edge would show up as a second capture;
- a strobe held on through a whole pulse, to show the pulse is not retriggered.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

    localparam int TS_W = 16;

    typedef logic [TS_W-1:0] ts_t;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_HIGH = 1'b1
    } pulse_state_t;

    typedef struct packed {
        ts_t  stamp;
        logic flag;
        logic ovr;
    } cap_state_t;

    function automatic logic overrun_next(input logic flag, input logic ovr,
                                          input logic clr);
        return (flag & ~clr) | (ovr & ~clr);
    endfunction

endpackage

// File: rtl/tsl_bit_pulse.sv
module tsl_bit_pulse
    import tsl_pkg::*;
#(
    parameter int PULSE_BITS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_ok_i,
    input  logic bit_tick_i,
    output logic pulse_o
);
    localparam int CNT_W = (PULSE_BITS > 1) ? $clog2(PULSE_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_BITS - 1);

    pulse_state_t    st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PL_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                PL_IDLE: begin
                    if (frame_ok_i) begin
                        st_q  <= PL_HIGH;
                        cnt_q <= '0;
                    end
                end
                PL_HIGH: begin
                    if (bit_tick_i) begin
                        if (cnt_q == LAST) st_q <= PL_IDLE;
                        else               cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= PL_IDLE;
            endcase
        end
    end

    assign pulse_o = (st_q == PL_HIGH);
endmodule

// File: rtl/tsl_free_timer.sv
module tsl_free_timer
    import tsl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output ts_t  count_o
);
    ts_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/tsl_route_edge.sv
module tsl_route_edge (
    input  logic clk,
    input  logic rst,
    input  logic link_en_i,
    input  logic pulse_i,
    input  logic ext_i,
    output logic rise_o
);
    logic sel_q;
    logic prev_q;
    logic src;
    logic switch_now;

    assign src        = sel_q ? pulse_i : ext_i;
    assign switch_now = !pulse_i && (link_en_i != sel_q);
    assign rise_o     = src && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            prev_q <= 1'b0;
        end else if (switch_now) begin
            sel_q  <= link_en_i;
            prev_q <= link_en_i ? pulse_i : ext_i;
        end else begin
            prev_q <= src;
        end
    end
endmodule

// File: rtl/tsl_capture.sv
module tsl_capture
    import tsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise_i,
    input  ts_t        timer_i,
    input  logic       clr_i,
    output cap_state_t state_o
);
    cap_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (rise_i) begin
            st_q.stamp <= timer_i;
            st_q.flag  <= 1'b1;
            st_q.ovr   <= overrun_next(st_q.flag, st_q.ovr, clr_i);
        end else if (clr_i) begin
            st_q.flag <= 1'b0;
            st_q.ovr  <= 1'b0;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/can_rx_tstamp_link.sv
module can_rx_tstamp_link
    import tsl_pkg::*;
#(
    parameter int PULSE_BITS = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_ok_i,
    input  logic        bit_tick_i,
    input  logic        link_en_i,
    input  logic        ext_cap_i,
    input  logic        tmr_tick_i,
    input  logic        flag_clr_i,
    output logic        link_pulse_o,
    output logic [15:0] timer_o,
    output logic [15:0] tstamp_o,
    output logic        cap_flag_o,
    output logic        overrun_o
);
    logic       pulse;
    logic       rise;
    ts_t        tmr;
    cap_state_t cap;

    tsl_bit_pulse #(.PULSE_BITS(PULSE_BITS)) u_pulse (
        .clk(clk), .rst(rst), .frame_ok_i(frame_ok_i),
        .bit_tick_i(bit_tick_i), .pulse_o(pulse)
    );

    tsl_free_timer u_timer (
        .clk(clk), .rst(rst), .tick_i(tmr_tick_i), .count_o(tmr)
    );

    tsl_route_edge u_route (
        .clk(clk), .rst(rst), .link_en_i(link_en_i), .pulse_i(pulse),
        .ext_i(ext_cap_i), .rise_o(rise)
    );

    tsl_capture u_cap (
        .clk(clk), .rst(rst), .rise_i(rise), .timer_i(tmr),
        .clr_i(flag_clr_i), .state_o(cap)
    );

    assign link_pulse_o = pulse;
    assign timer_o      = tmr;
    assign tstamp_o     = cap.stamp;
    assign cap_flag_o   = cap.flag;
    assign overrun_o    = cap.ovr;
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker (
    input logic        clk,
    input logic        rst,
    input logic        frame_ok_i,
    input logic        bit_tick_i,
    input logic        tmr_tick_i,
    input logic        flag_clr_i,
    input logic        link_pulse_o,
    input logic [15:0] timer_o,
    input logic [15:0] tstamp_o,
    input logic        cap_flag_o,
    input logic        overrun_o
);
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(link_pulse_o) |-> $past(frame_ok_i)); // R1

    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (link_pulse_o && !bit_tick_i) |=> link_pulse_o); // R2

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        tmr_tick_i |=> (timer_o == $past(timer_o) + 16'd1)); // R5

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tmr_tick_i |=> $stable(timer_o)); // R5

    AST_STAMP_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !$stable(tstamp_o) |-> cap_flag_o); // R6

    AST_CLEAR_WINS_NO_OVR: assert property (@(posedge clk) disable iff (rst)
        flag_clr_i |=> !overrun_o); // R7

    AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> (cap_flag_o && $past(cap_flag_o))); // R8
endmodule

bind can_rx_tstamp_link tsl_checker u_chk (
    .clk(clk), .rst(rst), .frame_ok_i(frame_ok_i), .bit_tick_i(bit_tick_i),
    .tmr_tick_i(tmr_tick_i), .flag_clr_i(flag_clr_i),
    .link_pulse_o(link_pulse_o), .timer_o(timer_o), .tstamp_o(tstamp_o),
    .cap_flag_o(cap_flag_o), .overrun_o(overrun_o)
);

// File: tb/sim_can_rx_tstamp_link.sv
module sim_can_rx_tstamp_link;
    localparam int PB = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_ok_i = 0, bit_tick_i = 0, link_en_i = 0, ext_cap_i = 0;
    logic tmr_tick_i = 0, flag_clr_i = 0;
    logic link_pulse_o, cap_flag_o, overrun_o;
    logic [15:0] timer_o, tstamp_o;

    always #2.5 clk = ~clk;

    can_rx_tstamp_link #(.PULSE_BITS(PB)) u0 (
        .clk(clk), .rst(rst), .frame_ok_i(frame_ok_i), .bit_tick_i(bit_tick_i),
        .link_en_i(link_en_i), .ext_cap_i(ext_cap_i), .tmr_tick_i(tmr_tick_i),
        .flag_clr_i(flag_clr_i), .link_pulse_o(link_pulse_o), .timer_o(timer_o),
        .tstamp_o(tstamp_o), .cap_flag_o(cap_flag_o), .overrun_o(overrun_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference state, derived from the requirements
    logic        m_pulse, m_sel, m_prev, m_flag, m_ovr;
    int          m_cnt;
    logic [15:0] m_timer, m_ts;
    int          m_caps;

    function automatic logic route_src(input logic sel, input logic p, input logic e);
        return sel ? p : e;
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pulse = 0; m_sel = 0; m_prev = 0; m_flag = 0; m_ovr = 0;
        m_cnt = 0; m_timer = 0; m_ts = 0; m_caps = 0;
    endtask

    // one clock: advance model with the inputs present at the edge, then compare
    task automatic step();
        logic src, rise, n_sel, n_prev;
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            src  = route_src(m_sel, m_pulse, ext_cap_i);
            rise = src && !m_prev;
            if (!m_pulse && link_en_i != m_sel) begin   // R9
                n_sel  = link_en_i;
                n_prev = route_src(link_en_i, m_pulse, ext_cap_i);
            end else begin
                n_sel  = m_sel;
                n_prev = src;
            end
            if (rise) begin                              // R6 R7 R8
                m_ts   = m_timer;
                m_ovr  = (m_flag || m_ovr) && !flag_clr_i;
                m_flag = 1;
                m_caps++;
            end else if (flag_clr_i) begin
                m_flag = 0; m_ovr = 0;
            end
            m_sel = n_sel; m_prev = n_prev;
            if (tmr_tick_i) m_timer = m_timer + 16'd1;   // R5
            if (!m_pulse) begin                          // R1 R3
                if (frame_ok_i) begin m_pulse = 1; m_cnt = 0; end
            end else if (bit_tick_i) begin               // R2
                if (m_cnt == PB - 1) m_pulse = 0;
                else m_cnt++;
            end
        end
        @(negedge clk);
        chk("R1/R2/R3 pulse", {15'd0, link_pulse_o}, {15'd0, m_pulse});
        chk("R5 timer", timer_o, m_timer);
        chk("R6 tstamp", tstamp_o, m_ts);
        chk("R7 flag", {15'd0, cap_flag_o}, {15'd0, m_flag});
        chk("R8 overrun", {15'd0, overrun_o}, {15'd0, m_ovr});
    endtask

    task automatic idle_inputs();
        frame_ok_i = 0; bit_tick_i = 0; tmr_tick_i = 0; flag_clr_i = 0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int caps0;
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        frame_ok_i = 1; tmr_tick_i = 1; ext_cap_i = 1;
        step(); step();
        // R10 reset values
        chk("R10 reset pulse", {15'd0, link_pulse_o}, 16'd0);
        chk("R10 reset timer", timer_o, 16'd0);
        chk("R10 reset flag", {15'd0, cap_flag_o}, 16'd0);
        rst = 0; idle_inputs(); ext_cap_i = 0;
        step();

        // R4: link on, one strobe -> one capture, pulse rises next cycle (R1)
        link_en_i = 1; step(); step();
        caps0 = m_caps;
        frame_ok_i = 1; step(); frame_ok_i = 0;
        chk("R1 pulse after strobe", {15'd0, link_pulse_o}, 16'd1);
        step();
        chk("R4 capture one cycle after rise", {15'd0, cap_flag_o}, 16'd1);
        // R3: strobe held during pulse is ignored
        frame_ok_i = 1; step(); step(); frame_ok_i = 0;
        chk("R3 pulse held without tick", {15'd0, link_pulse_o}, 16'd1);
        bit_tick_i = 1; step(); bit_tick_i = 0;
        chk("R2 pulse ends after tick", {15'd0, link_pulse_o}, 16'd0);
        step();
        chk("R4 one capture per pulse", 16'(m_caps - caps0), 16'd1);
        chk("R8 no overrun", {15'd0, overrun_o}, 16'd0);

        // R9: clear link during pulse with external input high
        flag_clr_i = 1; step(); flag_clr_i = 0;
        ext_cap_i = 1;
        frame_ok_i = 1; step(); frame_ok_i = 0;
        step();
        link_en_i = 0; step(); step();
        bit_tick_i = 1; step(); bit_tick_i = 0;
        step(); step();
        chk("R9 no false capture on route change", {15'd0, overrun_o}, 16'd0);
        ext_cap_i = 0; step();
        // R4 external route capture
        caps0 = m_caps;
        ext_cap_i = 1; step(); step();
        chk("R4 external capture", 16'(m_caps - caps0), 16'd1);
        chk("R8 overrun after second capture", {15'd0, overrun_o}, 16'd1);
        ext_cap_i = 0;
        flag_clr_i = 1; step(); flag_clr_i = 0;

        // R5 wrap: tick every cycle through 0xFFFF
        tmr_tick_i = 1;
        for (int i = 0; i < 65540; i++) step();
        tmr_tick_i = 0;

        // random mix
        for (int i = 0; i < 20000; i++) begin
            frame_ok_i = ($urandom_range(0, 19) == 0);
            bit_tick_i = ($urandom_range(0, 3) == 0);
            tmr_tick_i = $urandom_range(0, 1);
            flag_clr_i = ($urandom_range(0, 24) == 0);
            if ($urandom_range(0, 49) == 0) link_en_i = ~link_en_i;
            if ($urandom_range(0, 9) == 0) ext_cap_i = ~ext_cap_i;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule